// File: doc/BRIEF.md
# Two-Port Root Hub Power Control Registers

This block holds the configuration and status bytes of a two-port root hub and turns byte-wide register writes into port power decisions. Software writes one byte per cycle at a byte address inside a small window and reads any byte back combinationally from the same address. Two descriptor words set the power switching scheme: gang, masked, or no switching. They also hold a per-port power-control mask and per-port fixed-device flags. A hub word carries global power commands and a remote-wakeup enable. One word per port holds connect status, the power bit and a set of change flags.

The power switching mode decides how a power command reaches each port. A global off or on command acts on both ports in gang mode. In masked mode it acts only on ports whose mask bit is clear. When no switching is selected, global commands are ignored. A per-port command acts only in gang mode, and only on a port whose mask bit is set. A port that loses power has its status and change flags wiped. A separate controller-reset strobe loads a fixed pattern into both ports' change flags. Each port's registered power bit drives a power-enable pin.

Register access is a plain strobe interface with no back-pressure: every write is taken in the cycle it is presented. There is no data stream, so the block has no valid/ready pair.

Top module: `rh_power_regs`

## Requirements
- R1: After reset, descriptor A byte 0 (address 0x00) reads 0x02, every other byte reads 0x00, and both power-enable outputs are low.
- R2: Descriptor A byte 1 (0x01) stores the written value ANDed with 0x1B. Descriptor A byte 3 (0x03) stores it ANDed with 0x03. Bits [1:0] of byte 1 are the switching mode: 00 gang, 01 masked, 1x no switching.
- R3: Writes to the following bytes change nothing: descriptor A bytes 0 and 2 (0x00, 0x02), descriptor B bytes 1 and 3 (0x05, 0x07), port status byte 0 (0x0C, 0x10) and port byte 3 (0x0F, 0x13). Hub bytes 0 and 2 (0x08, 0x0A) always read 0x00.
- R4: A write to descriptor A byte 1 with bit 1 set turns on the power bit of both ports.
- R5: Descriptor B bytes 0 and 2 (0x04, 0x06) store the written value ANDed with 0x06. Bit 1+i of byte 0 is port i's fixed-device flag, and bit 1+i of byte 2 is port i's power mask. On a write to byte 0, every port whose flag bit is written as 0 gets connect (status bit 0) set. If connect was clear before the write, the port's change bit 0 is also set.
- R6: Writing 1 to hub byte 0 bit 0 removes power from both ports in gang mode, and only from ports with a clear mask bit in masked mode. It has no effect when no switching is selected.
- R7: Writing 1 to hub byte 2 bit 0 applies power under the same mode and mask rules as R6.
- R8: A port that loses power has bits 0x17 cleared in both its status byte (0x0C+4i) and its change byte (0x0E+4i).
- R9: Writing 1 to hub byte 1 bit 7 (0x09) sets remote-wakeup enable, which reads back as bit 7 of 0x09. Writing 1 to hub byte 3 bit 7 (0x0B) clears it.
- R10: Writing port change byte 2 clears each of bits 0 to 4 that is written as 1 and leaves the others unchanged.
- R11: In gang mode, a write to port byte 1 (0x0D+4i) acts only if that port's mask bit is set. Bit 1 removes power (with R8), and bit 0 applies power. When both bits are set, the wipe happens and power ends on.
- R12: The controller-reset strobe loads 0x16 into both change bytes. This takes precedence over a write in the same cycle.
- R13: Port i's power bit reads back as bit 0 of its byte 1 and drives port_pwr_o[i]. Both change on the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 5 | Byte address for reads and writes |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data at addr |
| ctrl_reset_stb | input | 1 | Controller reset strobe, loads change bytes |
| port_pwr_o | output | 2 | Per-port power enable |

## Verification
The global power commands are exercised under every combination of the four mode codes and the four mask values, with a changing fixed-device pattern each time. Because of that, a port that wrongly follows the mask in gang mode, or ignores it in masked mode, shows a different power pattern from a correct one. Per-port commands are driven in the same sweep, so the mask-gated behaviour is told apart from the gang-only behaviour. Value sweeps on the masked descriptor bytes and writes of 0xFF to the read-only bytes separate the kept bits from the dropped ones. One case drives a clear write and the reset strobe together to confirm the precedence rule.

// File: rtl/rh_pkg.sv
package rh_pkg;
  localparam int unsigned NUM_PORTS   = 2;
  localparam int unsigned REG_DESC_A  = 0;
  localparam int unsigned REG_DESC_B  = 1;
  localparam int unsigned REG_HUB     = 2;
  localparam int unsigned REG_PORT0   = 3;
  localparam logic [4:0]  WIPE_BITS   = 5'b10111;
  localparam logic [4:0]  CHG_RST_VAL = 5'b10110;
  localparam logic [7:0]  DA1_KEEP    = 8'h1B;
  localparam logic [7:0]  DA3_KEEP    = 8'h03;
  localparam logic [7:0]  DB_KEEP     = 8'h06;

  typedef struct packed {
    logic       off;
    logic       on;
    logic       conn;
    logic [4:0] clr;
  } port_cmd_t;
endpackage

// File: rtl/rh_desc_regs.sv
module rh_desc_regs
  import rh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_a1,
  input  logic       wr_a3,
  input  logic       wr_b0,
  input  logic       wr_b2,
  input  logic [7:0] wdata,
  output logic [7:0] da1_q,
  output logic [7:0] da3_q,
  output logic [7:0] db0_q,
  output logic [7:0] db2_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      da1_q <= '0;
      da3_q <= '0;
      db0_q <= '0;
      db2_q <= '0;
    end else begin
      if (wr_a1) da1_q <= wdata & DA1_KEEP;
      if (wr_a3) da3_q <= wdata & DA3_KEEP;
      if (wr_b0) db0_q <= wdata & DB_KEEP;
      if (wr_b2) db2_q <= wdata & DB_KEEP;
    end
  end

  a_r2_mode_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a1 |=> da1_q[1:0] == $past(wdata[1:0]));
endmodule

// File: rtl/rh_port_slot.sv
module rh_port_slot
  import rh_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  port_cmd_t cmd,
  input  logic      ctrl_reset_stb,
  output logic [4:0] st_q,
  output logic [4:0] ch_q,
  output logic       pwr_q
);
  logic [4:0] st_d, ch_d;
  logic       pwr_d;

  always_comb begin
    st_d  = st_q;
    ch_d  = ch_q;
    pwr_d = pwr_q;
    if (cmd.off) begin
      st_d  = st_d & ~WIPE_BITS;
      ch_d  = ch_d & ~WIPE_BITS;
      pwr_d = 1'b0;
    end
    if (cmd.on) pwr_d = 1'b1;
    if (cmd.conn) begin
      if (!st_q[0]) ch_d[0] = 1'b1;
      st_d[0] = 1'b1;
    end
    ch_d = ch_d & ~cmd.clr;
    if (ctrl_reset_stb) ch_d = CHG_RST_VAL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= '0;
      ch_q  <= '0;
      pwr_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ch_q  <= ch_d;
      pwr_q <= pwr_d;
    end
  end

  a_r8_off_wipes: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.off && !cmd.on && !cmd.conn && !ctrl_reset_stb) |=>
      (!pwr_q && ((st_q & WIPE_BITS) == 5'd0) && ((ch_q & WIPE_BITS) == 5'd0)));
  a_r12_strobe_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_reset_stb |=> ch_q == CHG_RST_VAL);
  a_r5_conn_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.conn && !cmd.off) |=> st_q[0]);
  a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd.clr != 5'd0) && !ctrl_reset_stb && !cmd.conn) |=> ((ch_q & $past(cmd.clr)) == 5'd0));
endmodule

// File: rtl/rh_power_regs.sv
module rh_power_regs
  import rh_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rd_data,
  input  logic              ctrl_reset_stb,
  output logic [NUM_PORTS-1:0] port_pwr_o
);
  localparam int unsigned REG_W = ADDR_W - 2;
  localparam logic [7:0]  PORT_COUNT = 8'(NUM_PORTS);

  logic [REG_W-1:0] reg_idx;
  logic [1:0]       byte_idx;
  assign reg_idx  = addr[ADDR_W-1:2];
  assign byte_idx = addr[1:0];

  function automatic logic hit(input logic [REG_W-1:0] r, input logic [1:0] b,
                               input int unsigned rr, input int unsigned bb);
    return (int'(r) == int'(rr)) && (int'(b) == int'(bb));
  endfunction

  logic wr_a1, wr_a3, wr_b0, wr_b2;
  assign wr_a1 = wr_en && hit(reg_idx, byte_idx, REG_DESC_A, 1);
  assign wr_a3 = wr_en && hit(reg_idx, byte_idx, REG_DESC_A, 3);
  assign wr_b0 = wr_en && hit(reg_idx, byte_idx, REG_DESC_B, 0);
  assign wr_b2 = wr_en && hit(reg_idx, byte_idx, REG_DESC_B, 2);

  logic [7:0] da1_q, da3_q, db0_q, db2_q;

  rh_desc_regs u_desc (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_a1 (wr_a1),
    .wr_a3 (wr_a3),
    .wr_b0 (wr_b0),
    .wr_b2 (wr_b2),
    .wdata (wdata),
    .da1_q (da1_q),
    .da3_q (da3_q),
    .db0_q (db0_q),
    .db2_q (db2_q)
  );

  logic [1:0] mode;
  logic       mode_gang, mode_masked;
  assign mode        = da1_q[1:0];
  assign mode_gang   = (mode == 2'b00);
  assign mode_masked = (mode == 2'b01);

  logic glob_off, glob_on, wr_wake_set, wr_wake_clr;
  assign glob_off    = wr_en && hit(reg_idx, byte_idx, REG_HUB, 0) && wdata[0];
  assign glob_on     = wr_en && hit(reg_idx, byte_idx, REG_HUB, 2) && wdata[0];
  assign wr_wake_set = wr_en && hit(reg_idx, byte_idx, REG_HUB, 1) && wdata[7];
  assign wr_wake_clr = wr_en && hit(reg_idx, byte_idx, REG_HUB, 3) && wdata[7];

  logic wake_en_q;
  always_ff @(posedge clk) begin
    if (!rst_n)           wake_en_q <= 1'b0;
    else if (wr_wake_set) wake_en_q <= 1'b1;
    else if (wr_wake_clr) wake_en_q <= 1'b0;
  end

  port_cmd_t        cmd   [NUM_PORTS];
  logic [4:0]       st_q  [NUM_PORTS];
  logic [4:0]       ch_q  [NUM_PORTS];
  logic [NUM_PORTS-1:0] pwr_q;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    logic mask_bit, fixed_bit, follows_glob, own_ok, wr_b1, wr_b2p;
    assign mask_bit     = db2_q[i+1];
    assign fixed_bit    = wdata[i+1];
    assign follows_glob = mode_gang || (mode_masked && !mask_bit);
    assign own_ok       = mode_gang && mask_bit;
    assign wr_b1        = wr_en && hit(reg_idx, byte_idx, REG_PORT0 + i, 1);
    assign wr_b2p       = wr_en && hit(reg_idx, byte_idx, REG_PORT0 + i, 2);

    assign cmd[i].off  = (glob_off && follows_glob) || (wr_b1 && own_ok && wdata[1]);
    assign cmd[i].on   = (glob_on && follows_glob) || (wr_b1 && own_ok && wdata[0]) ||
                         (wr_a1 && wdata[1]);
    assign cmd[i].conn = wr_b0 && !fixed_bit;
    assign cmd[i].clr  = wr_b2p ? wdata[4:0] : 5'd0;

    rh_port_slot u_slot (
      .clk            (clk),
      .rst_n          (rst_n),
      .cmd            (cmd[i]),
      .ctrl_reset_stb (ctrl_reset_stb),
      .st_q           (st_q[i]),
      .ch_q           (ch_q[i]),
      .pwr_q          (pwr_q[i])
    );
  end

  assign port_pwr_o = pwr_q;

  always_comb begin
    rd_data = 8'h00;
    if (int'(reg_idx) == int'(REG_DESC_A)) begin
      case (byte_idx)
        2'd0:    rd_data = PORT_COUNT;
        2'd1:    rd_data = da1_q;
        2'd3:    rd_data = da3_q;
        default: rd_data = 8'h00;
      endcase
    end else if (int'(reg_idx) == int'(REG_DESC_B)) begin
      case (byte_idx)
        2'd0:    rd_data = db0_q;
        2'd2:    rd_data = db2_q;
        default: rd_data = 8'h00;
      endcase
    end else if (int'(reg_idx) == int'(REG_HUB)) begin
      if (byte_idx == 2'd1) rd_data = {wake_en_q, 7'd0};
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (int'(reg_idx) == int'(REG_PORT0) + p) begin
          case (byte_idx)
            2'd0:    rd_data = {3'd0, st_q[p]};
            2'd1:    rd_data = {7'd0, pwr_q[p]};
            2'd2:    rd_data = {3'd0, ch_q[p]};
            default: rd_data = 8'h00;
          endcase
        end
      end
    end
  end

  a_r6_noswitch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_off && mode[1]) |=> $stable(port_pwr_o));
  a_r9_wake_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_wake_set |=> wake_en_q);
  a_r9_wake_clr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_wake_clr |=> !wake_en_q);
  a_r7_gang_on: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_on && mode_gang) |=> (port_pwr_o == '1));
endmodule

// File: tb/sim_rh_power_regs.sv
`timescale 1ns/1ps
module sim_rh_power_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rd_data;
  logic       ctrl_reset_stb = 1'b0;
  logic [1:0] port_pwr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rh_power_regs u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .ctrl_reset_stb(ctrl_reset_stb), .port_pwr_o(port_pwr_o)
  );

  // expected state, built from the requirement text
  logic [7:0] m_da1, m_da3, m_db0, m_db2;
  logic       m_wake;
  logic [4:0] m_st [2];
  logic [4:0] m_ch [2];
  logic [1:0] m_pw;

  task automatic model_reset();
    m_da1 = 0; m_da3 = 0; m_db0 = 0; m_db2 = 0; m_wake = 0; m_pw = 0;
    for (int i = 0; i < 2; i++) begin m_st[i] = 0; m_ch[i] = 0; end
  endtask

  task automatic model_apply(input logic [4:0] a, input logic [7:0] d, input bit we, input bit stb);
    int r = int'(a[4:2]);
    int b = int'(a[1:0]);
    logic [1:0] md = m_da1[1:0];
    bit off [2], on [2], cn [2];
    logic [4:0] cl [2];
    for (int i = 0; i < 2; i++) begin
      bit grp = (md == 2'b00) || (md == 2'b01 && !m_db2[i+1]);
      bit own = (md == 2'b00) && m_db2[i+1];
      off[i] = we && ((r == 2 && b == 0 && d[0] && grp) || (r == 3 + i && b == 1 && own && d[1]));
      on[i]  = we && ((r == 2 && b == 2 && d[0] && grp) || (r == 3 + i && b == 1 && own && d[0]) ||
                      (r == 0 && b == 1 && d[1]));
      cn[i]  = we && r == 1 && b == 0 && !d[i+1];
      cl[i]  = (we && r == 3 + i && b == 2) ? d[4:0] : 5'd0;
    end
    for (int i = 0; i < 2; i++) begin
      if (off[i]) begin m_st[i] &= 5'b01000; m_ch[i] &= 5'b01000; m_pw[i] = 0; end
      if (on[i]) m_pw[i] = 1;
      if (cn[i]) begin if (!m_st[i][0]) m_ch[i][0] = 1; m_st[i][0] = 1; end
      m_ch[i] &= ~cl[i];
      if (stb) m_ch[i] = 5'h16;
    end
    if (we) begin
      if (r == 0 && b == 1) m_da1 = d & 8'h1B;
      if (r == 0 && b == 3) m_da3 = d & 8'h03;
      if (r == 1 && b == 0) m_db0 = d & 8'h06;
      if (r == 1 && b == 2) m_db2 = d & 8'h06;
      if (r == 2 && b == 1 && d[7]) m_wake = 1;
      if (r == 2 && b == 3 && d[7]) m_wake = 0;
    end
  endtask

  function automatic logic [7:0] exp_rd(input int a);
    int r = a / 4;
    int b = a % 4;
    case (r)
      0: return (b == 0) ? 8'h02 : (b == 1) ? m_da1 : (b == 3) ? m_da3 : 8'h00;
      1: return (b == 0) ? m_db0 : (b == 2) ? m_db2 : 8'h00;
      2: return (b == 1) ? {m_wake, 7'd0} : 8'h00;
      3, 4: return (b == 0) ? {3'd0, m_st[r-3]} : (b == 1) ? {7'd0, m_pw[r-3]} :
                   (b == 2) ? {3'd0, m_ch[r-3]} : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic wr(input logic [4:0] a, input logic [7:0] d, input bit we, input bit stb);
    @(negedge clk);
    addr = a; wdata = d; wr_en = we; ctrl_reset_stb = stb;
    @(posedge clk);
    #1;
    wr_en = 0; ctrl_reset_stb = 0;
    model_apply(a, d, we, stb);
  endtask

  task automatic check_all(input string tag);
    @(negedge clk);
    for (int a = 0; a < 24; a++) begin
      addr = 5'(a);
      #0.08;
      checks++;
      if (rd_data !== exp_rd(a)) begin
        errors++;
        $display("FAIL %s addr 0x%02h: actual 0x%02h expected 0x%02h", tag, a, rd_data, exp_rd(a));
      end
    end
    checks++;
    if (port_pwr_o !== m_pw) begin
      errors++;
      $display("FAIL %s R13 power pins: actual %b expected %b", tag, port_pwr_o, m_pw);
    end
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check_all("R1 reset state");

    // R2 R5: masked descriptor bytes over a value sweep
    for (int v = 0; v < 256; v += 17) begin
      wr(5'h01, 8'(v), 1, 0); check_all("R2 R4 desc A byte 1");
      wr(5'h03, 8'(v), 1, 0); check_all("R2 desc A byte 3");
      wr(5'h04, 8'(v), 1, 0); check_all("R5 desc B byte 0 and connect");
      wr(5'h06, 8'(v), 1, 0); check_all("R5 desc B byte 2");
    end

    // R3: read-only bytes
    foreach (addr_ro[k]) begin
      wr(addr_ro[k], 8'hFF, 1, 0); check_all("R3 read-only byte");
    end

    // R9: wakeup enable
    wr(5'h09, 8'h80, 1, 0); check_all("R9 wake set");
    wr(5'h0B, 8'h7F, 1, 0); check_all("R9 wake clear needs bit 7");
    wr(5'h0B, 8'h80, 1, 0); check_all("R9 wake clear");

    // R6 R7 R8 R11: every mode and mask
    for (int md = 0; md < 4; md++) begin
      for (int mk = 0; mk < 4; mk++) begin
        wr(5'h01, 8'(md | 8'h08), 1, 0); check_all("R4 mode select");
        wr(5'h06, 8'(mk << 1), 1, 0);
        wr(5'h04, 8'(((md ^ mk) & 3) << 1), 1, 0); check_all("R5 connect forcing");
        wr(5'h0A, 8'h01, 1, 0); check_all("R7 global on");
        wr(5'h08, 8'h01, 1, 0); check_all("R6 R8 global off");
        wr(5'h0D, 8'h01, 1, 0); check_all("R11 port 0 on");
        wr(5'h11, 8'h01, 1, 0); check_all("R11 port 1 on");
        wr(5'h0D, 8'h02, 1, 0); check_all("R11 R8 port 0 off");
        wr(5'h11, 8'h03, 1, 0); check_all("R11 port 1 off and on");
        wr(5'h00, 8'h00, 0, 1); check_all("R12 strobe");
        wr(5'h0E, 8'(mk * 5 + md), 1, 0); check_all("R10 change clear");
        wr(5'h12, 8'h1F, 1, 0); check_all("R10 change clear all");
      end
    end

    // R12: strobe wins over a same-cycle clear
    wr(5'h0E, 8'h1F, 1, 1); check_all("R12 strobe precedence");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [4:0] addr_ro [8] = '{5'h00, 5'h02, 5'h05, 5'h07, 5'h0C, 5'h0F, 5'h10, 5'h13};
endmodule